// File: doc/BRIEF.md
# GPIO Port Controller with Configuration Lock

This block drives a set of GPIO ports. Each port has up to 16 pins and is reached through a flat register space with synchronous writes. Every port holds an output register with three write aliases: set, clear and toggle. Each alias changes only the bits given in its mask, in a single write. Each port also has a synchronized view of its input pads, a 4-bit mode field for each pin, and a control register that carries two slew-rate fields. One field applies to pins in normal modes and the other to pins in alternate modes. The pad outputs (value, enable, pull enable and pull direction) are decoded from each pin's mode and its output bit.

A global register bank holds the configuration lock, a lock status register, an interrupt pin-select word and a routing word. Writing the unlock key releases the lock and writing any other value engages it. While the lock is engaged, writes to the mode, control, interrupt-select and routing registers are dropped. The output register and its aliases stay writable. The `PIN_MASK` parameter gives the implemented pins of each port. Unimplemented pins store nothing, read as zero and drive nothing.

Address map: bits [2:0] of `addr` select the register and the upper bits select the port. Port index `NPORTS` selects the global bank. Port registers are 0 output, 1 set alias, 2 clear alias, 3 toggle alias, 4 input, 5 modes of pins 0-7, 6 modes of pins 8-15, and 7 control. In both mode registers, pin k occupies bits [4(k%8)+3 : 4(k%8)]. Global registers are 0 lock key, 1 lock status, 2 interrupt pin select and 3 routing. Reads are combinational, and the alias and key addresses read as zero.

Top module: `gpio_lockport`

## Requirements
- R1: After reset, all output bits, mode fields, control fields, interrupt-select and routing words are 0. The lock is released (status reads 0) and no pad is driven or pulled.
- R2: A write of exactly 32'h0000A534 to the lock key register releases the lock. A write of any other 32-bit value engages it. Lock status bit 0 reads 1 when locked and 0 when unlocked, and shows the new state in the cycle after the write.
- R3: While locked, writes to the mode registers, the control register, the interrupt-select register and the routing register are dropped, and reads return the stored values.
- R4: The output register and its set, clear and toggle aliases are written normally while locked.
- R5: A write to the set alias ORs the mask into the output register. A write to the clear alias clears the masked bits. A write to the toggle alias inverts the masked bits. Unmasked bits are unchanged.
- R6: In the control register, the normal-mode slew field sits at bits [SLEW_W-1:0] and the alternate-mode slew field sits at bits [16+SLEW_W-1:16]. Each field reads back independently.
- R7: Each pad input reaches the input register through two flops. A pad change made before rising edge n is readable after rising edge n+1 and is not yet readable after edge n.
- R8: For pins whose `PIN_MASK` bit is 0, writes have no effect, reads of output, input and mode return 0, and all four pad outputs are 0.
- R9: Mode decoding: 0 is off and 1 is input, both with no drive and no pull. 2 is input with pull, where pull enable is 1 and the pull direction equals the output bit. 3 is push-pull, where the enable is 1 and the value equals the output bit. 4 is open-drain, where the enable is the inverse of the output bit and the value is 0. 5 is open-drain with pull-up, which adds pull enable 1 and direction 1. Codes 6 to 15 behave as off.
- R10: Reading the output register returns the last value written to it, independent of the pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address: port select above bit 3, register in bits [2:0] |
| we | input | 1 | Write enable for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | NPORTS*PINS | Pad input levels |
| pad_out | output | NPORTS*PINS | Pad output value |
| pad_oe | output | NPORTS*PINS | Pad output enable |
| pad_pull_en | output | NPORTS*PINS | Pad pull enable |
| pad_pull_up | output | NPORTS*PINS | Pull direction, 1 for up |

## Verification
A write takes effect at the rising edge on which `we` is sampled. That includes the lock state and the pad outputs derived from modes and output bits. The bench therefore drives each write from one falling edge to the next and reads back combinationally at the following falling edge. Pad input changes need two rising edges before the input register shows them. The bench checks the input register once after the first edge, expecting the old value, and once after the second, expecting the new one.

// File: rtl/gpio_lockport.sv
module gpio_lockport #(
  parameter int NPORTS = 2,
  parameter int PINS = 16,
  parameter int SLEW_W = 3,
  parameter logic [NPORTS*PINS-1:0] PIN_MASK = 32'h0FFF_FFFF,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_A534,
  localparam int PSEL_W = $clog2(NPORTS + 1),
  localparam int ADDR_W = PSEL_W + 3,
  localparam int NP = NPORTS * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NP-1:0]     pad_in,
  output logic [NP-1:0]     pad_out,
  output logic [NP-1:0]     pad_oe,
  output logic [NP-1:0]     pad_pull_en,
  output logic [NP-1:0]     pad_pull_up
);
  localparam logic [2:0] R_DOUT = 3'd0, R_SET = 3'd1, R_CLR = 3'd2, R_TGL = 3'd3;
  localparam logic [2:0] R_DIN = 3'd4, R_MODEL = 3'd5, R_MODEH = 3'd6, R_CTRL = 3'd7;
  localparam logic [2:0] G_KEY = 3'd0, G_STAT = 3'd1, G_IRQ = 3'd2, G_ROUTE = 3'd3;
  localparam logic [PSEL_W-1:0] GLOB = PSEL_W'(NPORTS);

  logic [NPORTS-1:0][PINS-1:0]       dout_q;
  logic [NPORTS-1:0][PINS-1:0][3:0]  mode_q;
  logic [NPORTS-1:0][SLEW_W-1:0]     slew_n_q, slew_a_q;
  logic [31:0]                       irqsel_q, route_q;
  logic                              lock_q;
  logic [NP-1:0]                     sync1_q, sync2_q;

  wire [PSEL_W-1:0] port_sel = addr[ADDR_W-1:3];
  wire [2:0]        reg_sel  = addr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      mode_q   <= '0;
      slew_n_q <= '0;
      slew_a_q <= '0;
      irqsel_q <= '0;
      route_q  <= '0;
      lock_q   <= 1'b0;
    end else if (we) begin
      if (port_sel == GLOB) begin
        case (reg_sel)
          G_KEY:   lock_q <= (wdata != UNLOCK_KEY);
          G_IRQ:   if (!lock_q) irqsel_q <= wdata;
          G_ROUTE: if (!lock_q) route_q <= wdata;
          default: ;
        endcase
      end else begin
        for (int p = 0; p < NPORTS; p++) begin
          if (port_sel == PSEL_W'(p)) begin
            case (reg_sel)
              R_DOUT: dout_q[p] <= wdata[PINS-1:0] & PIN_MASK[p*PINS +: PINS];
              R_SET:  dout_q[p] <= dout_q[p] | (wdata[PINS-1:0] & PIN_MASK[p*PINS +: PINS]);
              R_CLR:  dout_q[p] <= dout_q[p] & ~(wdata[PINS-1:0] & PIN_MASK[p*PINS +: PINS]);
              R_TGL:  dout_q[p] <= dout_q[p] ^ (wdata[PINS-1:0] & PIN_MASK[p*PINS +: PINS]);
              R_CTRL: if (!lock_q) begin
                slew_n_q[p] <= wdata[SLEW_W-1:0];
                slew_a_q[p] <= wdata[16 +: SLEW_W];
              end
              default: ;
            endcase
            if (!lock_q) begin
              for (int i = 0; i < PINS; i++) begin
                if (reg_sel == ((i < 8) ? R_MODEL : R_MODEH))
                  mode_q[p][i] <= PIN_MASK[p*PINS+i] ? wdata[(i%8)*4 +: 4] : 4'd0;
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (port_sel == GLOB) begin
      case (reg_sel)
        G_STAT:  rdata[0] = lock_q;
        G_IRQ:   rdata = irqsel_q;
        G_ROUTE: rdata = route_q;
        default: ;
      endcase
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (port_sel == PSEL_W'(p)) begin
          case (reg_sel)
            R_DOUT: rdata[PINS-1:0] = dout_q[p];
            R_DIN:  rdata[PINS-1:0] = sync2_q[p*PINS +: PINS] & PIN_MASK[p*PINS +: PINS];
            R_CTRL: begin
              rdata[SLEW_W-1:0]   = slew_n_q[p];
              rdata[16 +: SLEW_W] = slew_a_q[p];
            end
            default: ;
          endcase
          for (int i = 0; i < PINS; i++) begin
            if (reg_sel == ((i < 8) ? R_MODEL : R_MODEH))
              rdata[(i%8)*4 +: 4] = mode_q[p][i];
          end
        end
      end
    end
  end

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
      localparam int K = gp * PINS + gi;
      wire [3:0] m = mode_q[gp][gi];
      wire       d = dout_q[gp][gi];
      wire       od = (m == 4'd4) || (m == 4'd5);
      assign pad_out[K]     = (m == 4'd3) & d;
      assign pad_oe[K]      = (m == 4'd3) | (od & ~d);
      assign pad_pull_en[K] = (m == 4'd2) | (m == 4'd5);
      assign pad_pull_up[K] = ((m == 4'd2) & d) | (m == 4'd5);
    end
  end
endmodule

module gpio_lockport_chk #(
  parameter int NPORTS = 2,
  parameter int PINS = 16,
  parameter logic [NPORTS*PINS-1:0] PIN_MASK = 32'h0FFF_FFFF,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_A534,
  localparam int PSEL_W = $clog2(NPORTS + 1),
  localparam int ADDR_W = PSEL_W + 3,
  localparam int NP = NPORTS * PINS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [31:0]       wdata,
  input logic [NP-1:0]     pad_out,
  input logic [NP-1:0]     pad_oe,
  input logic              lock_q,
  input logic [NP-1:0]     dout_flat,
  input logic [NP*4-1:0]   mode_flat
);
  localparam logic [ADDR_W-1:0] A_KEY = {PSEL_W'(NPORTS), 3'd0};
  localparam logic [ADDR_W-1:0] A_SET0 = {PSEL_W'(0), 3'd1};
  localparam logic [PINS-1:0] MASK0 = PIN_MASK[PINS-1:0];

  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_KEY && wdata == UNLOCK_KEY) |=> !lock_q); // R2
  AST_BADKEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_KEY && wdata != UNLOCK_KEY) |=> lock_q); // R2
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mode_flat)); // R3
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_SET0) |=>
      ((dout_flat[PINS-1:0] & $past(wdata[PINS-1:0]) & MASK0) == ($past(wdata[PINS-1:0]) & MASK0))); // R5
  AST_UNIMPL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_flat & ~PIN_MASK) == '0) && (pad_oe & ~PIN_MASK) == '0); // R8
  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0); // R9
endmodule

bind gpio_lockport gpio_lockport_chk #(
  .NPORTS(NPORTS), .PINS(PINS), .PIN_MASK(PIN_MASK), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .lock_q(lock_q),
  .dout_flat(dout_q), .mode_flat(mode_q)
);

// File: tb/gpio_lockport_tb.sv
`timescale 1ns/1ps
module gpio_lockport_tb;
  localparam int NPORTS = 2;
  localparam int PINS = 16;
  localparam int NP = NPORTS * PINS;
  localparam int ADDR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_lockport u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
  );

  function automatic logic [ADDR_W-1:0] pa(int port, int r);
    return ADDR_W'(port * 8 + r);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(pa(0, 0), v); check("R1 dout", v, 0);
    rd(pa(0, 5), v); check("R1 mode", v, 0);
    rd(pa(1, 7), v); check("R1 ctrl", v, 0);
    rd(pa(2, 1), v); check("R1 status", v, 0);
    rd(pa(2, 2), v); check("R1 irqsel", v, 0);
    check("R1 pads", {pad_oe | pad_out | pad_pull_en | pad_pull_up}, 0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(pa(0, 0), 32'h0000_00F0);
    rd(pa(0, 0), v); check("R10 dout write", v, 32'h00F0);
    wr(pa(0, 1), 32'h0000_0003);
    rd(pa(0, 0), v); check("R5 set", v, 32'h00F3);
    wr(pa(0, 2), 32'h0000_00F0);
    rd(pa(0, 0), v); check("R5 clear", v, 32'h0003);
    wr(pa(0, 3), 32'h0000_0101);
    rd(pa(0, 0), v); check("R5 toggle", v, 32'h0102);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(pa(0, 5), 32'h0000_0033);
    wr(pa(0, 7), 32'h0005_0003);
    wr(pa(2, 2), 32'h0000_00AA);
    wr(pa(2, 3), 32'h0000_0055);
    rd(pa(0, 7), v); check("R6 slew fields", v, 32'h0005_0003);
    wr(pa(2, 0), 32'h0000_1234);
    rd(pa(2, 1), v); check("R2 wrong key locks", v, 1);
    wr(pa(0, 5), 32'h0000_0000);
    rd(pa(0, 5), v); check("R3 mode frozen", v, 32'h33);
    wr(pa(0, 7), 32'h0000_0000);
    rd(pa(0, 7), v); check("R3 ctrl frozen", v, 32'h0005_0003);
    wr(pa(2, 2), 32'h0);
    rd(pa(2, 2), v); check("R3 irqsel frozen", v, 32'hAA);
    wr(pa(2, 3), 32'h0);
    rd(pa(2, 3), v); check("R3 route frozen", v, 32'h55);
    wr(pa(0, 0), 32'h0000_FFFF);
    rd(pa(0, 0), v); check("R4 dout while locked", v, 32'hFFFF);
    wr(pa(0, 2), 32'h0000_0F00);
    rd(pa(0, 0), v); check("R4 clear while locked", v, 32'hF0FF);
    wr(pa(2, 0), 32'h0000_A534);
    rd(pa(2, 1), v); check("R2 key unlocks", v, 0);
    wr(pa(0, 7), 32'h0002_0006);
    rd(pa(0, 7), v); check("R6 slew rewrite", v, 32'h0002_0006);
    wr(pa(2, 0), 32'h0001_A534);
    rd(pa(2, 1), v); check("R2 upper bits lock", v, 1);
    wr(pa(2, 0), 32'h0000_A534);
    rd(pa(2, 1), v); check("R2 unlock again", v, 0);
  endtask

  task automatic t_pads();
    wr(pa(0, 5), 32'h0000_5243);
    wr(pa(0, 0), 32'h0000_0007);
    #1;
    check("R9 oe hi", {28'h0, pad_oe[3:0]}, 32'b1001);
    check("R9 out hi", {28'h0, pad_out[3:0]}, 32'b0001);
    check("R9 pull_en hi", {28'h0, pad_pull_en[3:0]}, 32'b1100);
    check("R9 pull_up hi", {28'h0, pad_pull_up[3:0]}, 32'b1100);
    wr(pa(0, 0), 32'h0000_0000);
    #1;
    check("R9 oe lo", {28'h0, pad_oe[3:0]}, 32'b1011);
    check("R9 out lo", {28'h0, pad_out[3:0]}, 32'b0000);
    check("R9 pull_up lo", {28'h0, pad_pull_up[3:0]}, 32'b1000);
    wr(pa(0, 5), 32'h0000_0007);
    #1 check("R9 reserved code", {31'h0, pad_oe[0] | pad_pull_en[0]}, 0);
  endtask

  task automatic t_din();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'hFFFF_A5C3;
    @(negedge clk);
    rd(pa(0, 4), v); check("R7 not after one edge", v, 0);
    @(negedge clk);
    rd(pa(0, 4), v); check("R7 after two edges", v, 32'hA5C3);
    rd(pa(1, 4), v); check("R8 din masked", v, 32'h0FFF);
    rd(pa(0, 0), v); check("R10 dout not pads", v, 0);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(pa(1, 0), 32'h0000_FFFF);
    rd(pa(1, 0), v); check("R8 dout masked", v, 32'h0FFF);
    wr(pa(1, 6), 32'h3333_3333);
    rd(pa(1, 6), v); check("R8 mode masked", v, 32'h0000_3333);
    #1;
    check("R8 pads idle", {28'h0, pad_oe[31:28] | pad_out[31:28]}, 0);
    check("R9 port1 drive", {28'h0, pad_out[27:24]}, 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_lock();
    t_pads();
    t_din();
    t_unimpl();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule